// File: doc/BRIEF.md
# Burst-Counted SPI Master

This block is a serial peripheral master driven from a small word-addressed register bus. Software loads bytes into a transmit queue, programs how many bytes the next exchange lasts, and sets a start bit. The engine then shifts exactly that many bytes, most significant bit first, in any of the four clock polarity and phase modes. Every received byte goes into a receive queue, and the start bit drops by itself when the last byte is complete.

The serial clock does not come from a divider inside the block. An external strobe `tick_i` marks each half period of the serial clock, so the bit rate is set by whoever drives the strobe. Four chip-select lines are provided. Software picks one of them and either lets the engine assert it for the length of the exchange or drives its level directly.

Register map (word index on `addr_i`):

| Index | Register | Fields |
|---|---|---|
| 0 | global control | bit 0 enable, bit 1 master, bit 31 soft reset (pulse) |
| 1 | exchange control | bit 0 clock phase, bit 1 clock polarity, bit 2 select active low, bits [5:4] line select, bit 6 manual select, bit 7 manual level, bit 31 start |
| 2 | queue control | bit 15 receive flush, bit 31 transmit flush (both pulses) |
| 3 | queue status | [7:0] receive level, [15:8] transmit level, bit 16 overflow |
| 4 | burst length | [23:0] bytes to exchange |
| 5 | transmit length | [23:0] bytes taken from the transmit queue |
| 6 | transmit data | write pushes [7:0] |
| 7 | receive data | read pops, data in [7:0] |

Top module: `spi_burst_master`

## Requirements
- R1: After reset, global control reads 0, exchange control reads 0x4, queue status reads 0, `sck_o` and `mosi_o` are 0 and all four lines of `cs_o` are 1.
- R2: A started exchange shifts exactly burst-length bytes, bit 7 of each byte first. `sck_o` changes only on a cycle with `tick_i` high, and each byte takes 16 strobes.
- R3: `sck_o` idles at the clock polarity bit. With clock phase 0, `miso_i` is sampled on the edge leaving the idle level. With phase 1, it is sampled on the edge returning to the idle level. The received byte is stored bit 7 first.
- R4: Exchange control bit 31 reads 1 from the write that sets it until the last byte of the burst is done, and then reads 0.
- R5: When the transmit queue is empty during a burst, the remaining bytes are sent as 0x00.
- R6: Only the first transmit-length bytes of a burst are taken from the transmit queue. Later bytes are sent as 0x00 and stay in the queue, as seen in status bits [15:8].
- R7: Each received byte is queued. Status bits [7:0] give the receive level, and reading index 7 returns the oldest byte and removes it.
- R8: A byte received while the receive queue is full is dropped and sets status bit 16. This bit stays set until the receive queue is flushed.
- R9: Writing 1 to queue control bit 31 empties the transmit queue. Writing 1 to bit 15 empties the receive queue and clears the overflow bit. Both bits read back 0.
- R10: In manual mode (bit 6), the selected line (bits [5:4]) follows bit 7. In automatic mode, the selected line is active while an exchange runs. Active is 0 when bit 2 is set and 1 otherwise. Unselected lines always sit at the inactive level.
- R11: Clearing the enable bit during an exchange stops it within one cycle. The start bit clears, `sck_o` returns to idle, and no further bytes are received.
- R12: Writing 1 to global control bit 31 empties both queues and stops any exchange. The bit reads back 0.
- R13: A start request is ignored unless both enable and master are set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| req_i | input | 1 | register access this cycle |
| we_i | input | 1 | 1 write, 0 read |
| addr_i | input | 3 | register word index |
| wdata_i | input | 32 | write data |
| rdata_o | output | 32 | read data, combinational from `addr_i` |
| tick_i | input | 1 | serial half-period strobe |
| miso_i | input | 1 | serial data in |
| sck_o | output | 1 | serial clock |
| mosi_o | output | 1 | serial data out |
| cs_o | output | 4 | chip-select lines |

## Verification
A register write takes effect at the clock edge that captures it. The engine reacts to a start or an enable change one edge later, so `cs_o` and the start bit are read back only after at least one further clock cycle. A byte completes 16 strobes after it is loaded, and the bench strobes every second cycle. For that reason, burst results are never sampled at a fixed delay: the bench polls the start bit until it reads 0, and only then reads the status and data registers. The bench captures serial bits at negative clock edges, on the edge the selected mode defines, and feeds back the inverted output as `miso_i`. This gives a transmit check and a receive check that are independent of each other.

// File: rtl/spi_burst_pkg.sv
package spi_burst_pkg;
  localparam int CS_N  = 4;
  localparam int SEL_W = $clog2(CS_N);

  typedef enum logic [2:0] {
    A_GCTL  = 3'd0,
    A_XCTL  = 3'd1,
    A_FCTL  = 3'd2,
    A_FSTAT = 3'd3,
    A_BURST = 3'd4,
    A_XMIT  = 3'd5,
    A_TXD   = 3'd6,
    A_RXD   = 3'd7
  } reg_addr_e;

  localparam int GC_EN    = 0;
  localparam int GC_MST   = 1;
  localparam int GC_SRST  = 31;
  localparam int XC_CPHA  = 0;
  localparam int XC_CPOL  = 1;
  localparam int XC_ALOW  = 2;
  localparam int XC_SEL   = 4;
  localparam int XC_MAN   = 6;
  localparam int XC_LVL   = 7;
  localparam int XC_START = 31;
  localparam int FC_RXRST = 15;
  localparam int FC_TXRST = 31;
  localparam int FS_OVF   = 16;
endpackage

// File: rtl/spi_byte_fifo.sv
module spi_byte_fifo #(
  parameter int DEPTH = 64,
  parameter int W     = 8,
  parameter int LW    = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          flush_i,
  input  logic          push_i,
  input  logic [W-1:0]  din_i,
  input  logic          pop_i,
  output logic [W-1:0]  dout_o,
  output logic          empty_o,
  output logic          full_o,
  output logic [LW-1:0] level_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wptr_q, rptr_q;
  logic [LW-1:0] cnt_q;
  logic          push_ok, pop_ok;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == LW'(DEPTH));
  assign level_o = cnt_q;
  assign push_ok = push_i && !full_o;
  assign pop_ok  = pop_i && !empty_o;
  assign dout_o  = mem_q[rptr_q];

  always_ff @(posedge clk_i) begin
    if (push_ok) mem_q[wptr_q] <= din_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else if (flush_i) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (push_ok) wptr_q <= (wptr_q == AW'(DEPTH - 1)) ? '0 : wptr_q + 1'b1;
      if (pop_ok)  rptr_q <= (rptr_q == AW'(DEPTH - 1)) ? '0 : rptr_q + 1'b1;
      if (push_ok && !pop_ok)      cnt_q <= cnt_q + 1'b1;
      else if (pop_ok && !push_ok) cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine #(
  parameter int CNT_W = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             abort_i,
  input  logic             go_i,
  input  logic             cpol_i,
  input  logic             cpha_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] burst_i,
  input  logic [CNT_W-1:0] xmit_i,
  input  logic             tx_empty_i,
  input  logic [7:0]       tx_data_i,
  output logic             tx_pop_o,
  input  logic             miso_i,
  output logic             sck_o,
  output logic             mosi_o,
  output logic             busy_o,
  output logic             rx_push_o,
  output logic [7:0]       rx_data_o,
  output logic             done_o
);
  logic             busy_q, sck_q, mosi_q;
  logic [3:0]       half_q;
  logic [CNT_W-1:0] left_q, fetch_q, fetch_base;
  logic [7:0]       tx_sh_q, rx_sh_q, next_byte;
  logic             start_c, last_c, load_c, use_fifo_c, lead_c, final_c;

  always_comb begin
    start_c    = go_i && !busy_q && !abort_i && (burst_i != '0);
    last_c     = busy_q && tick_i && !abort_i && (half_q == 4'hF);
    final_c    = (left_q == CNT_W'(1));
    load_c     = start_c || (last_c && !final_c);
    fetch_base = busy_q ? fetch_q : '0;
    use_fifo_c = (fetch_base < xmit_i) && !tx_empty_i;
    next_byte  = use_fifo_c ? tx_data_i : 8'h00;
    lead_c     = !half_q[0];
    tx_pop_o   = load_c && use_fifo_c;
    rx_push_o  = last_c;
    rx_data_o  = cpha_i ? {rx_sh_q[6:0], miso_i} : rx_sh_q;
    done_o     = (go_i && !busy_q && !abort_i && (burst_i == '0)) || (last_c && final_c);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      sck_q   <= 1'b0;
      mosi_q  <= 1'b0;
      half_q  <= '0;
      left_q  <= '0;
      fetch_q <= '0;
      tx_sh_q <= '0;
      rx_sh_q <= '0;
    end else if (abort_i) begin
      busy_q <= 1'b0;
      sck_q  <= cpol_i;
      mosi_q <= 1'b0;
      half_q <= '0;
    end else begin
      if (!busy_q) begin
        sck_q  <= cpol_i;
        mosi_q <= 1'b0;
      end else if (tick_i) begin
        sck_q  <= ~sck_q;
        half_q <= half_q + 1'b1;
        if (lead_c) begin
          if (cpha_i) begin
            mosi_q  <= tx_sh_q[7];
            tx_sh_q <= {tx_sh_q[6:0], 1'b0};
          end else begin
            rx_sh_q <= {rx_sh_q[6:0], miso_i};
          end
        end else begin
          if (cpha_i) begin
            rx_sh_q <= {rx_sh_q[6:0], miso_i};
          end else if (half_q != 4'hF) begin
            mosi_q  <= tx_sh_q[7];
            tx_sh_q <= {tx_sh_q[6:0], 1'b0};
          end
        end
        if (last_c) begin
          if (final_c) busy_q <= 1'b0;
          left_q <= left_q - 1'b1;
        end
      end
      if (start_c) begin
        busy_q <= 1'b1;
        left_q <= burst_i;
        half_q <= '0;
        sck_q  <= cpol_i;
      end
      if (load_c) begin
        fetch_q <= fetch_base + (use_fifo_c ? CNT_W'(1) : CNT_W'(0)) + (use_fifo_c ? CNT_W'(0) : CNT_W'(1));
        if (cpha_i) begin
          tx_sh_q <= next_byte;
        end else begin
          mosi_q  <= next_byte[7];
          tx_sh_q <= {next_byte[6:0], 1'b0};
        end
      end
    end
  end

  assign sck_o  = sck_q;
  assign mosi_o = mosi_q;
  assign busy_o = busy_q;
endmodule

// File: rtl/spi_burst_master.sv
module spi_burst_master
  import spi_burst_pkg::*;
#(
  parameter int FIFO_DEPTH = 64,
  parameter int CNT_W      = 24
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            req_i,
  input  logic            we_i,
  input  logic [2:0]      addr_i,
  input  logic [31:0]     wdata_i,
  output logic [31:0]     rdata_o,
  input  logic            tick_i,
  input  logic            miso_i,
  output logic            sck_o,
  output logic            mosi_o,
  output logic [CS_N-1:0] cs_o
);
  localparam int LVL_W = $clog2(FIFO_DEPTH + 1);

  reg_addr_e        addr;
  logic             wr, rd;
  logic             en_q, master_q, srst_q, txf_q, rxf_q, start_q, ovf_q;
  logic             cpha_q, cpol_q, act_low_q, manual_q, level_q;
  logic [SEL_W-1:0] sel_q;
  logic [CNT_W-1:0] burst_q, xmit_q;
  logic             abort, tx_flush, rx_flush;
  logic             eng_busy, eng_done, tx_pop, rx_push;
  logic [7:0]       tx_head, rx_head, rx_byte;
  logic             tx_empty, tx_full, rx_empty, rx_full;
  logic [LVL_W-1:0] tx_lvl, rx_lvl;
  logic             unused_wdata;

  assign addr         = reg_addr_e'(addr_i);
  assign wr           = req_i && we_i;
  assign rd           = req_i && !we_i;
  assign abort        = !en_q || srst_q;
  assign tx_flush     = txf_q || srst_q;
  assign rx_flush     = rxf_q || srst_q;
  assign unused_wdata = ^{wdata_i[30:16], wdata_i[14:8], wdata_i[3]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q      <= 1'b0;
      master_q  <= 1'b0;
      srst_q    <= 1'b0;
      txf_q     <= 1'b0;
      rxf_q     <= 1'b0;
      cpha_q    <= 1'b0;
      cpol_q    <= 1'b0;
      act_low_q <= 1'b1;
      sel_q     <= '0;
      manual_q  <= 1'b0;
      level_q   <= 1'b0;
      burst_q   <= '0;
      xmit_q    <= '0;
    end else begin
      srst_q <= wr && (addr == A_GCTL) && wdata_i[GC_SRST];
      txf_q  <= wr && (addr == A_FCTL) && wdata_i[FC_TXRST];
      rxf_q  <= wr && (addr == A_FCTL) && wdata_i[FC_RXRST];
      if (wr) begin
        case (addr)
          A_GCTL: begin
            en_q     <= wdata_i[GC_EN];
            master_q <= wdata_i[GC_MST];
          end
          A_XCTL: begin
            cpha_q    <= wdata_i[XC_CPHA];
            cpol_q    <= wdata_i[XC_CPOL];
            act_low_q <= wdata_i[XC_ALOW];
            sel_q     <= wdata_i[XC_SEL +: SEL_W];
            manual_q  <= wdata_i[XC_MAN];
            level_q   <= wdata_i[XC_LVL];
          end
          A_BURST: burst_q <= wdata_i[CNT_W-1:0];
          A_XMIT:  xmit_q  <= wdata_i[CNT_W-1:0];
          default: ;
        endcase
      end
    end
  end

  // start bit: set by software only when enabled as master, cleared by hardware
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  start_q <= 1'b0;
    else if (abort || eng_done)   start_q <= 1'b0;
    else if (wr && (addr == A_XCTL) && wdata_i[XC_START] && en_q && master_q)
                                  start_q <= 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  ovf_q <= 1'b0;
    else if (rx_flush)            ovf_q <= 1'b0;
    else if (rx_push && rx_full)  ovf_q <= 1'b1;
  end

  spi_byte_fifo #(.DEPTH(FIFO_DEPTH), .W(8), .LW(LVL_W)) u_tx_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (tx_flush),
    .push_i  (wr && (addr == A_TXD)),
    .din_i   (wdata_i[7:0]),
    .pop_i   (tx_pop),
    .dout_o  (tx_head),
    .empty_o (tx_empty),
    .full_o  (tx_full),
    .level_o (tx_lvl)
  );

  spi_byte_fifo #(.DEPTH(FIFO_DEPTH), .W(8), .LW(LVL_W)) u_rx_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (rx_flush),
    .push_i  (rx_push),
    .din_i   (rx_byte),
    .pop_i   (rd && (addr == A_RXD)),
    .dout_o  (rx_head),
    .empty_o (rx_empty),
    .full_o  (rx_full),
    .level_o (rx_lvl)
  );

  spi_shift_engine #(.CNT_W(CNT_W)) u_engine (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .abort_i    (abort),
    .go_i       (start_q),
    .cpol_i     (cpol_q),
    .cpha_i     (cpha_q),
    .tick_i     (tick_i),
    .burst_i    (burst_q),
    .xmit_i     (xmit_q),
    .tx_empty_i (tx_empty),
    .tx_data_i  (tx_head),
    .tx_pop_o   (tx_pop),
    .miso_i     (miso_i),
    .sck_o      (sck_o),
    .mosi_o     (mosi_o),
    .busy_o     (eng_busy),
    .rx_push_o  (rx_push),
    .rx_data_o  (rx_byte),
    .done_o     (eng_done)
  );

  for (genvar i = 0; i < CS_N; i++) begin : g_cs
    assign cs_o[i] = (sel_q == SEL_W'(i)) ? (manual_q ? level_q : (eng_busy ^ act_low_q))
                                          : act_low_q;
  end

  always_comb begin
    rdata_o = '0;
    case (addr)
      A_GCTL:  rdata_o = {30'd0, master_q, en_q};
      A_XCTL:  rdata_o = {start_q, 23'd0, level_q, manual_q, 2'(sel_q), 1'b0, act_low_q, cpol_q, cpha_q};
      A_FSTAT: rdata_o = {15'd0, ovf_q, 8'(tx_lvl), 8'(rx_lvl)};
      A_BURST: rdata_o = 32'(burst_q);
      A_XMIT:  rdata_o = 32'(xmit_q);
      A_RXD:   rdata_o = {24'd0, rx_empty ? 8'h00 : rx_head};
      default: rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/spi_burst_master_chk.sv
module spi_burst_master_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       tick_i,
  input logic       sck_o,
  input logic [3:0] cs_o,
  input logic       busy,
  input logic       start,
  input logic       en,
  input logic       srst,
  input logic       ovf,
  input logic       rx_flush,
  input logic       act_low
);
  assert_sck_tick_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && en && !srst && !tick_i) |=> $stable(sck_o));

  assert_start_clear_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy) |-> !start);

  assert_busy_gate_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy) |-> ($past(en) && $past(start)));

  assert_ovf_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf && !rx_flush) |=> ovf);

  assert_cs_single_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(cs_o ^ {4{act_low}}) <= 1);
endmodule

bind spi_burst_master spi_burst_master_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .tick_i   (tick_i),
  .sck_o    (sck_o),
  .cs_o     (cs_o),
  .busy     (eng_busy),
  .start    (start_q),
  .en       (en_q),
  .srst     (srst_q),
  .ovf      (ovf_q),
  .rx_flush (rx_flush),
  .act_low  (act_low_q)
);

// File: tb/spi_burst_master_bench.sv
module spi_burst_master_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        tick = 1'b0;
  logic        miso, sck, mosi;
  logic [3:0]  cs;

  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  logic       tb_cpol = 1'b0, tb_cpha = 1'b0;
  logic       mon_clr = 1'b0, sck_prev = 1'b0;
  logic [7:0] mon_sh = '0;
  int         mon_bits = 0, mon_n = 0;
  logic [7:0] mon_q [0:127];

  localparam logic [2:0] GCTL = 3'd0, XCTL = 3'd1, FCTL = 3'd2, FSTAT = 3'd3,
                         BURST = 3'd4, XMIT = 3'd5, TXD = 3'd6, RXD = 3'd7;

  always #2.5ns clk = ~clk;
  always @(negedge clk) tick <= ~tick;
  assign miso = ~mosi;

  spi_burst_master u_spi_burst_master (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .tick_i(tick), .miso_i(miso),
    .sck_o(sck), .mosi_o(mosi), .cs_o(cs)
  );

  // serial monitor: captures mosi on the sampling edge of the bench's mode
  always @(negedge clk) begin
    if (mon_clr) begin
      mon_n = 0; mon_bits = 0; sck_prev = sck; mon_clr = 1'b0;
    end else if (sck !== sck_prev) begin
      if (((sck_prev == tb_cpol) && !tb_cpha) || ((sck_prev != tb_cpol) && tb_cpha)) begin
        mon_sh = {mon_sh[6:0], mosi};
        mon_bits++;
        if (mon_bits == 8) begin
          if (mon_n < 128) mon_q[mon_n] = mon_sh;
          mon_n++;
          mon_bits = 0;
        end
      end
      sck_prev = sck;
    end
  end

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk); req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); req = 1'b1; we = 1'b0; addr = a;
    #1ns d = rdata;
    @(negedge clk); req = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_done();
    logic [31:0] v;
    for (int i = 0; i < 6000; i++) begin
      rd(XCTL, v);
      if (!v[31]) break;
    end
  endtask

  task automatic launch(input logic cpol, input logic cpha, input logic [31:0] xbits);
    tb_cpol = cpol; tb_cpha = cpha;
    wr(XCTL, xbits | {30'd0, cpol, cpha});
    idle(3);
    mon_clr = 1'b1;
    idle(2);
    wr(XCTL, 32'h8000_0000 | xbits | {30'd0, cpol, cpha});
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(GCTL, v);  chk(v, 32'h0, "R1 gctl");
    rd(XCTL, v);  chk(v, 32'h4, "R1 xctl");
    rd(FSTAT, v); chk(v, 32'h0, "R1 fstat");
    chk({28'd0, cs}, 32'hF, "R1 cs");
    chk({30'd0, sck, mosi}, 32'h0, "R1 sck/mosi");
  endtask

  task automatic t_basic();
    logic [31:0] v;
    wr(GCTL, 32'h3);
    wr(TXD, 32'hA5); wr(TXD, 32'h3C); wr(TXD, 32'h0F);
    wr(BURST, 3); wr(XMIT, 3);
    launch(1'b0, 1'b0, 32'h4);
    idle(2);
    chk({28'd0, cs}, 32'hE, "R10 auto cs active");
    rd(XCTL, v); chk({31'd0, v[31]}, 1, "R4 start held");
    wait_done();
    chk({28'd0, cs}, 32'hF, "R10 auto cs released");
    chk(mon_n, 3, "R2 byte count");
    chk(mon_q[0], 8'hA5, "R2 byte0"); chk(mon_q[1], 8'h3C, "R2 byte1"); chk(mon_q[2], 8'h0F, "R2 byte2");
    rd(FSTAT, v); chk(v[7:0], 3, "R7 rx level");
    rd(RXD, v); chk(v[7:0], 8'h5A, "R7 rx0");
    rd(RXD, v); chk(v[7:0], 8'hC3, "R7 rx1");
    rd(RXD, v); chk(v[7:0], 8'hF0, "R7 rx2");
    rd(FSTAT, v); chk(v, 0, "R7 drained");
  endtask

  task automatic t_modes();
    logic [31:0] v;
    for (int m = 1; m < 4; m++) begin
      wr(XCTL, 32'h4 | 32'(m));
      idle(3);
      chk({31'd0, sck}, 32'(m >> 1), "R3 idle level");
      wr(TXD, 32'h96); wr(BURST, 1); wr(XMIT, 1);
      launch(m[1], m[0], 32'h4);
      wait_done();
      chk(mon_n, 1, "R3 mode count");
      chk(mon_q[0], 8'h96, "R3 mode tx");
      rd(RXD, v); chk(v[7:0], 8'h69, "R3 mode rx");
      chk({31'd0, sck}, 32'(m >> 1), "R3 idle after");
    end
    wr(XCTL, 32'h4);
    idle(3);
  endtask

  task automatic t_tx_empty();
    logic [31:0] v;
    wr(TXD, 32'h81); wr(BURST, 3); wr(XMIT, 3);
    launch(1'b0, 1'b0, 32'h4);
    wait_done();
    chk(mon_q[0], 8'h81, "R5 first"); chk(mon_q[1], 8'h00, "R5 pad1"); chk(mon_q[2], 8'h00, "R5 pad2");
    rd(RXD, v); chk(v[7:0], 8'h7E, "R5 rx0");
    rd(RXD, v); chk(v[7:0], 8'hFF, "R5 rx1");
    rd(RXD, v); chk(v[7:0], 8'hFF, "R5 rx2");
  endtask

  task automatic t_xmit_limit();
    logic [31:0] v;
    wr(TXD, 32'h11); wr(TXD, 32'h22); wr(TXD, 32'h33);
    wr(BURST, 3); wr(XMIT, 1);
    launch(1'b0, 1'b0, 32'h4);
    wait_done();
    chk(mon_q[0], 8'h11, "R6 taken"); chk(mon_q[1], 8'h00, "R6 pad1"); chk(mon_q[2], 8'h00, "R6 pad2");
    rd(FSTAT, v); chk(v[15:8], 2, "R6 tx left");
    wr(FCTL, 32'h8000_0000);
    rd(FCTL, v); chk(v, 0, "R9 fctl reads 0");
    rd(FSTAT, v); chk(v[15:8], 0, "R9 tx flushed");
    chk(v[7:0], 3, "R9 rx untouched");
    wr(FCTL, 32'h0000_8000);
    rd(FSTAT, v); chk(v, 0, "R9 rx flushed");
  endtask

  task automatic t_overflow();
    logic [31:0] v;
    wr(BURST, 66); wr(XMIT, 0);
    launch(1'b0, 1'b0, 32'h4);
    wait_done();
    rd(FSTAT, v); chk(v[7:0], 64, "R8 level full"); chk({31'd0, v[16]}, 1, "R8 ovf set");
    rd(RXD, v); chk(v[7:0], 8'hFF, "R8 head");
    rd(FSTAT, v); chk({31'd0, v[16]}, 1, "R8 ovf sticky");
    wr(FCTL, 32'h0000_8000);
    rd(FSTAT, v); chk(v, 0, "R8 ovf cleared");
  endtask

  task automatic t_manual_cs();
    wr(XCTL, 32'h64); idle(2); chk({28'd0, cs}, 32'hB, "R10 manual low");
    wr(XCTL, 32'hE4); idle(2); chk({28'd0, cs}, 32'hF, "R10 manual high");
    wr(XCTL, 32'hF0); idle(2); chk({28'd0, cs}, 32'h8, "R10 active high sel3");
    wr(XCTL, 32'h4); idle(3);
  endtask

  task automatic t_abort();
    logic [31:0] v, lvl;
    wr(BURST, 4); wr(XMIT, 0);
    launch(1'b0, 1'b0, 32'h4);
    idle(40);
    wr(GCTL, 32'h0);
    rd(XCTL, v); chk({31'd0, v[31]}, 0, "R11 start cleared");
    chk({31'd0, sck}, 0, "R11 sck idle");
    rd(FSTAT, lvl);
    idle(200);
    rd(FSTAT, v); chk(v[7:0], lvl[7:0], "R11 no more rx");
    wr(FCTL, 32'h0000_8000);
    wr(BURST, 1);
    wr(XCTL, 32'h8000_0004);
    rd(XCTL, v); chk({31'd0, v[31]}, 0, "R13 disabled start ignored");
    wr(GCTL, 32'h1);
    wr(XCTL, 32'h8000_0004);
    rd(XCTL, v); chk({31'd0, v[31]}, 0, "R13 non-master start ignored");
    idle(100);
    rd(FSTAT, v); chk(v[7:0], 0, "R13 nothing received");
  endtask

  task automatic t_soft_reset();
    logic [31:0] v;
    wr(GCTL, 32'h3);
    wr(TXD, 32'h01); wr(TXD, 32'h02); wr(TXD, 32'h03);
    rd(FSTAT, v); chk(v[15:8], 3, "R12 tx loaded");
    wr(GCTL, 32'h8000_0003);
    rd(GCTL, v); chk(v, 32'h3, "R12 gctl bit31 reads 0");
    rd(FSTAT, v); chk(v, 0, "R12 queues empty");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(2);
    t_reset();
    t_basic();
    t_modes();
    t_tx_empty();
    t_xmit_limit();
    t_overflow();
    t_manual_cs();
    t_abort();
    t_soft_reset();
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule